// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block is a watchdog counter that raises a one-cycle reset request when it overflows. Software restarts the count only through a two-write handshake. The first write sets an arm flag. The second write sets a start flag, and it must arrive while the arm flag is still up. Each flag stays up for 12 clock cycles after it is written to 1, then clears itself. A start write that finds no arm flag does not reload a running counter. It can only start a counter that is stopped.

The flags sit at bit 6 of two interrupt-enable registers, which software reaches through a simple write port and a combinational read port. The other bits of those registers are plain storage. A reload register sets the timeout length: the counter restarts from the reload value and counts up on each cycle where `tick_en` is high.

Two state machines drive the behaviour:

- **Flag timer** (one copy per flag), with states `FLAG_CLEAR` and `FLAG_HELD`.
  - CLEAR to HELD on a write of 1.
  - HELD to HELD on a rewrite of 1, which restarts the 12-cycle age.
  - HELD to CLEAR when the age reaches 11, or on an early cut. Only the arm flag has an early cut, taken on a valid refresh.
- **Watchdog core**, with states `WD_STOPPED` and `WD_RUNNING`.
  - STOPPED to RUNNING on any start write.
  - RUNNING stays RUNNING until a synchronous reset.

Top module: `two_step_watchdog`

## Requirements
- R1: After synchronous reset, both flags read 0, the watchdog is stopped, the reload value is 0, every register reads 0 and `reset_req` is low. While stopped, `tick_en` never causes `reset_req`.
- R2: A write to address 0 with data bit 6 = 1 sets the arm flag. A write to address 0 with bit 6 = 0 leaves the arm flag unchanged.
- R3: The arm flag reads 1 for exactly 12 cycles after the edge that set it, then clears itself. Rewriting it with 1 while it is set restarts the 12 cycles.
- R4: A write to address 1 with bit 6 = 1 sets the start flag, which reads 1 for exactly 12 cycles after that edge. A write with bit 6 = 0 leaves it unchanged.
- R5: A start write made while the arm flag reads 1 is a valid refresh. At that edge the counter is loaded from the reload value and the arm flag clears.
- R6: A start write made while the arm flag is clear starts a stopped watchdog, loading the reload value. On a running watchdog it leaves the count unchanged.
- R7: A running counter increases by one on each cycle with `tick_en` high and holds otherwise. A stopped counter never counts.
- R8: A tick while the count is 0xFFFF raises `reset_req` for the following cycle, reloads the counter and keeps it running. A refresh or start load in that same cycle takes priority, and no request is raised.
- R9: The bits of addresses 0 and 1 other than bit 6 are plain read/write storage. Address 2 holds the reload low byte and address 3 the high byte, and both are readable.
- R10: `rd_data` follows `rd_addr` combinationally in the same cycle. A write becomes visible on the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count enable for the watchdog counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 = IE reg 0, 1 = IE reg 1, 2 = reload low, 3 = reload high) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 8 | Read data, combinational |
| reset_req | output | 1 | One-cycle reset request on counter overflow |
| flag_arm | output | 1 | Current value of the arm flag |
| flag_start | output | 1 | Current value of the start flag |

## Verification
A flag timer whose age is off by one shows up at the flag outputs and in the bit 6 readback within 12 cycles of a write. A wrong refresh or start decision does not show at once. It leaves the counter at the wrong value, and that appears only as a `reset_req` pulse early, late or missing, up to one full timeout later. The bench therefore keeps a behavioural model of the count, the flags, their ages and the stored registers, and compares every output on every cycle. It uses a short timeout so that a wrong reload surfaces within a few dozen ticks. The arm-to-start gap is swept across the 12-cycle window boundary.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic {
        WD_STOPPED = 1'b0,
        WD_RUNNING = 1'b1
    } wd_state_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_HELD  = 1'b1
    } flag_state_e;

    localparam int FLAG_BIT  = 6;
    localparam int REG_ADR_W = 2;
    localparam int REG_DAT_W = 8;

    localparam logic [REG_ADR_W-1:0] ADDR_IE0    = 2'd0;
    localparam logic [REG_ADR_W-1:0] ADDR_IE1    = 2'd1;
    localparam logic [REG_ADR_W-1:0] ADDR_REL_LO = 2'd2;

endpackage

// File: rtl/wd_flag_timer.sv
module wd_flag_timer #(
    parameter int HOLD = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic cut_i,
    output logic flag_o
);
    import wd_pkg::*;

    localparam int AGE_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(HOLD - 1);

    flag_state_e      state_q, state_n;
    logic [AGE_W-1:0] age_q;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (set_i) state_n = FLAG_HELD;
            end
            FLAG_HELD: begin
                if (set_i)
                    state_n = FLAG_HELD;
                else if (cut_i || age_q == AGE_LAST)
                    state_n = FLAG_CLEAR;
            end
            default: state_n = FLAG_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_CLEAR;
        else     state_q <= state_n;
    end

    // age counter: restarts on every write of 1
    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (set_i)
            age_q <= '0;
        else if (state_q == FLAG_HELD && state_n == FLAG_HELD)
            age_q <= age_q + 1'b1;
        else if (state_n == FLAG_CLEAR)
            age_q <= '0;
    end

    // outputs
    always_comb begin
        flag_o = (state_q == FLAG_HELD);
    end

endmodule

// File: rtl/wd_regfile.sv
module wd_regfile #(
    parameter int CNT_W = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [wd_pkg::REG_ADR_W-1:0]   wr_addr,
    input  logic [wd_pkg::REG_DAT_W-1:0]   wr_data,
    input  logic [wd_pkg::REG_ADR_W-1:0]   rd_addr,
    input  logic                           arm_flag,
    input  logic                           start_flag,
    output logic [CNT_W-1:0]               reload_o,
    output logic [wd_pkg::REG_DAT_W-1:0]   rd_data
);
    import wd_pkg::*;

    localparam int REL_BYTES = CNT_W / REG_DAT_W;
    localparam logic [REG_DAT_W-1:0] PLAIN_MASK = ~(REG_DAT_W'(1) << FLAG_BIT);

    logic [REG_DAT_W-1:0] ie0_q, ie1_q;

    // plain storage bits of the two interrupt-enable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ie0_q <= '0;
            ie1_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_IE0) ie0_q <= wr_data & PLAIN_MASK;
            if (wr_addr == ADDR_IE1) ie1_q <= wr_data & PLAIN_MASK;
        end
    end

    // reload register, one byte lane per address
    for (genvar b = 0; b < REL_BYTES; b++) begin : g_rel
        localparam logic [REG_ADR_W-1:0] LANE_ADDR = REG_ADR_W'(int'(ADDR_REL_LO) + b);
        logic [REG_DAT_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (wr_en && wr_addr == LANE_ADDR)
                lane_q <= wr_data;
        end
        assign reload_o[b*REG_DAT_W +: REG_DAT_W] = lane_q;
    end

    // combinational read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_IE0) begin
            rd_data = ie0_q;
            rd_data[FLAG_BIT] = arm_flag;
        end else if (rd_addr == ADDR_IE1) begin
            rd_data = ie1_q;
            rd_data[FLAG_BIT] = start_flag;
        end else begin
            for (int b = 0; b < REL_BYTES; b++) begin
                if (rd_addr == REG_ADR_W'(int'(ADDR_REL_LO) + b))
                    rd_data = reload_o[b*REG_DAT_W +: REG_DAT_W];
            end
        end
    end

endmodule

// File: rtl/wd_core.sv
module wd_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             running_o,
    output logic             reset_req_o
);
    import wd_pkg::*;

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    wd_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q;
    logic             load_now, expire;

    // events: a refresh, or a start of a stopped counter, loads it
    always_comb begin
        load_now = kick_i || (start_i && state_q == WD_STOPPED);
        expire   = (state_q == WD_RUNNING) && tick_i && (cnt_q == CNT_TOP) && !load_now;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WD_STOPPED: if (start_i) state_n = WD_RUNNING;
            WD_RUNNING: state_n = WD_RUNNING;
            default:    state_n = WD_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= WD_STOPPED;
        else     state_q <= state_n;
    end

    // counter
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_now || expire)
            cnt_q <= reload_i;
        else if (state_q == WD_RUNNING && tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) reset_req_o <= 1'b0;
        else     reset_req_o <= expire;
    end

    assign running_o = (state_q == WD_RUNNING);

endmodule

// File: rtl/two_step_watchdog.sv
module two_step_watchdog #(
    parameter int CNT_W       = 16,
    parameter int HOLD_CYCLES = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       reset_req,
    output logic       flag_arm,
    output logic       flag_start
);
    import wd_pkg::*;

    logic             arm_set, start_set, kick;
    logic             wd_running;
    logic [CNT_W-1:0] reload_val;

    // write decode for the two flag bits
    always_comb begin
        arm_set   = wr_en && (wr_addr == ADDR_IE0) && wr_data[FLAG_BIT];
        start_set = wr_en && (wr_addr == ADDR_IE1) && wr_data[FLAG_BIT];
        kick      = start_set && flag_arm;
    end

    wd_flag_timer #(.HOLD(HOLD_CYCLES)) u_arm (
        .clk    (clk),
        .rst    (rst),
        .set_i  (arm_set),
        .cut_i  (kick),
        .flag_o (flag_arm)
    );

    wd_flag_timer #(.HOLD(HOLD_CYCLES)) u_start (
        .clk    (clk),
        .rst    (rst),
        .set_i  (start_set),
        .cut_i  (1'b0),
        .flag_o (flag_start)
    );

    wd_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .arm_flag   (flag_arm),
        .start_flag (flag_start),
        .reload_o   (reload_val),
        .rd_data    (rd_data)
    );

    wd_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_en),
        .kick_i      (kick),
        .start_i     (start_set),
        .reload_i    (reload_val),
        .running_o   (wd_running),
        .reset_req_o (reset_req)
    );

endmodule

// File: rtl/wd_checker.sv
module wd_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       reset_req,
    input logic       flag_arm,
    input logic       flag_start,
    input logic       wd_running
);

    // R2: the arm flag only rises after a write of 1 to its bit
    assert_arm_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_arm) |-> $past(wr_en && wr_addr == 2'd0 && wr_data[6]));

    // R4: the start flag only rises after a write of 1 to its bit
    assert_start_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_start) |-> $past(wr_en && wr_addr == 2'd1 && wr_data[6]));

    // R5: a valid refresh drops the arm flag on the next cycle
    assert_arm_cut_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data[6] && flag_arm) |=> !flag_arm);

    // R8: a reset request follows a tick
    assert_req_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(tick_en));

    // R1: a stopped watchdog never requests a reset
    assert_stopped_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !wd_running |-> !reset_req);

endmodule

bind two_step_watchdog wd_checker u_wd_checker (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .reset_req  (reset_req),
    .flag_arm   (flag_arm),
    .flag_start (flag_start),
    .wd_running (wd_running)
);

// File: tb/tb_two_step_watchdog.sv
module tb_two_step_watchdog;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       reset_req, flag_arm, flag_start;

    int n_checks = 0;
    int n_errors = 0;
    int tick_mode = 0;   // 0: off, 1: always, 2: random

    two_step_watchdog dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .reset_req(reset_req),
        .flag_arm(flag_arm), .flag_start(flag_start)
    );

    always #10 clk = ~clk;   // 50 MHz

    // behavioural reference model
    int m_arm, m_arm_age, m_start, m_start_age, m_run, m_cnt, m_rel, m_req, m_ie0, m_ie1;

    always @(posedge clk) begin
        int w0, w1, kick;
        int n_arm, n_arm_age, n_st, n_st_age, n_run, n_cnt, n_req, n_rel;
        if (rst) begin
            m_arm = 0; m_arm_age = 0; m_start = 0; m_start_age = 0;
            m_run = 0; m_cnt = 0; m_rel = 0; m_req = 0; m_ie0 = 0; m_ie1 = 0;
        end else begin
            w0   = (wr_en && wr_addr == 2'd0 && wr_data[6]) ? 1 : 0;
            w1   = (wr_en && wr_addr == 2'd1 && wr_data[6]) ? 1 : 0;
            kick = (w1 != 0 && m_arm != 0) ? 1 : 0;
            n_arm = m_arm; n_arm_age = m_arm_age + 1;
            if (w0 != 0) begin n_arm = 1; n_arm_age = 0; end
            else if (m_arm != 0 && (kick != 0 || m_arm_age == 11)) n_arm = 0;
            n_st = m_start; n_st_age = m_start_age + 1;
            if (w1 != 0) begin n_st = 1; n_st_age = 0; end
            else if (m_start != 0 && m_start_age == 11) n_st = 0;
            n_req = 0; n_cnt = m_cnt; n_run = m_run;
            if (kick != 0 || (w1 != 0 && m_run == 0)) begin n_cnt = m_rel; n_run = 1; end
            else if (m_run != 0 && tick_en) begin
                if (m_cnt == 65535) begin n_req = 1; n_cnt = m_rel; end
                else n_cnt = m_cnt + 1;
            end
            n_rel = m_rel;
            if (wr_en && wr_addr == 2'd2) n_rel = (m_rel & 32'hFF00) | int'(wr_data);
            if (wr_en && wr_addr == 2'd3) n_rel = (m_rel & 32'h00FF) | (int'(wr_data) << 8);
            if (wr_en && wr_addr == 2'd0) m_ie0 = int'(wr_data) & 32'hBF;
            if (wr_en && wr_addr == 2'd1) m_ie1 = int'(wr_data) & 32'hBF;
            m_arm = n_arm; m_arm_age = n_arm_age; m_start = n_st; m_start_age = n_st_age;
            m_run = n_run; m_cnt = n_cnt; m_req = n_req; m_rel = n_rel;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_ie0 | (m_arm << 6);
            2'd1:    return m_ie1 | (m_start << 6);
            2'd2:    return m_rel & 32'hFF;
            default: return (m_rel >> 8) & 32'hFF;
        endcase
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 R6 R7 R8 reset_req", int'(reset_req), m_req);
            chk("R2 R3 R5 flag_arm", int'(flag_arm), m_arm);
            chk("R4 flag_start", int'(flag_start), m_start);
            chk("R9 R10 rd_data", int'(rd_data), model_rd(rd_addr));
        end
    end

    // tick and read-address stimulus, driven just after the edge
    always @(posedge clk) begin
        #2;
        rd_addr = rd_addr + 2'd1;
        if (tick_mode == 0)      tick_en = 1'b0;
        else if (tick_mode == 1) tick_en = 1'b1;
        else                     tick_en = ($urandom % 3) != 0;
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        #2 rst = 1'b0;
        // R1: reset state, ticks applied while stopped
        tick_mode = 1;
        @(negedge clk);
        chk("R1 reset_req", int'(reset_req), 0);
        chk("R1 flag_arm", int'(flag_arm), 0);
        chk("R1 flag_start", int'(flag_start), 0);
        idle(30);
        @(negedge clk);
        chk("R1 stopped no request", int'(reset_req), 0);

        // R9: reload and plain storage bits
        wr(2'd2, 8'hF0);
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'hBF);     // R2: bit 6 clear, flag unchanged
        wr(2'd1, 8'h25);     // R4: bit 6 clear, flag unchanged
        idle(4);

        // R6: start from stopped, let it expire twice (R8)
        wr(2'd1, 8'h40);
        idle(40);

        // R5: arm then start inside the window
        wr(2'd0, 8'h40); idle(4); wr(2'd1, 8'h40);
        idle(10);
        // R6: start alone while running leaves count
        wr(2'd1, 8'h40);
        idle(20);
        // R3: arm re-write restarts the window
        wr(2'd0, 8'h40); idle(6); wr(2'd0, 8'h41); idle(9); wr(2'd1, 8'h40);
        idle(25);

        // sweep gaps across the 12-cycle boundary, steady and random ticks
        for (int mode = 1; mode <= 2; mode++) begin
            tick_mode = mode;
            for (int gap = 0; gap <= 14; gap++) begin
                wr(2'd0, 8'h40);
                idle(gap);
                wr(2'd1, 8'h40);
                idle(7 + gap);
            end
        end

        // R8: overflow with reload 0xFFFE, refresh near expiry
        wr(2'd2, 8'hFE);
        tick_mode = 1;
        for (int k = 0; k < 6; k++) begin
            wr(2'd0, 8'h40);
            wr(2'd1, 8'h40);
            idle(k);
        end
        idle(12);
        tick_mode = 0;
        idle(20);
        @(negedge clk);
        chk("R7 held without ticks", int'(reset_req), 0);
        summary();
        $finish;
    end

endmodule